// File: doc/BRIEF.md
# Serial Stereo Audio Port with Volume

This block is the bit-serial audio edge of an effects processor. Two independent stereo streams arrive on two serial input lines. A frame sync pulse aligns them. Each frame lasts 32 bit-clocks and carries one stereo pair: a 16-bit left word followed by a 16-bit right word, both two's complement and sent MSB first. When the last bit of a frame has been clocked in, the block presents the four captured words in parallel, together with a one-cycle strobe.

In the same frame, the block shifts out a result pair on two serial output lines, one per stream. This is the pair that the effect engine presented on the result inputs at the end of the previous frame, so there is one frame of latency between result and wire. Before the pair is shifted out, an 8-bit master volume scales it. The gain is (volume + 1) / 256, applied with an arithmetic shift, so 0xFF passes samples unchanged. A volume of 0x00 forces silence.

A sync pulse that arrives early restarts the frame. The partial input is thrown away.

Top module: `stereo_serial_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `smp_valid` is 0 and the four parallel words and both serial outputs are 0.
- R2: Each serial input frame begins in the cycle where `sync` is 1. The left word takes bit-clocks 0 to 15 and the right word takes bit-clocks 16 to 31, each MSB first. The words appear on `in_l*`/`in_r*` in the cycle after bit-clock 31.
- R3: `smp_valid` is 1 for exactly one cycle after each completed frame. That is the same cycle in which the new words appear. At all other times the parallel words hold their values.
- R4: A `sync` that arrives before 32 bits have been counted restarts the frame at bit 0. The partial frame raises no strobe and changes no word.
- R5: The result pair on `res_*` in bit-clock 31 of a frame is shifted out during the following frame, in the same layout as the input (left MSB first, then right). The first bit is visible in the cycle after bit-clock 31, and each following clock moves to the next bit.
- R6: For a nonzero volume v, each outgoing word equals floor(sample × (v + 1) / 256). With v = 0xFF this is the sample unchanged.
- R7: With volume 0x00, both serial outputs stay 0 for the whole frame.
- R8: The gain for a frame uses the `volume` value from the clock before bit-clock 31. A change made during bit-clock 31 itself takes effect only from the next frame.
- R9: Stream 0 and stream 1 are handled independently. Each input line fills only its own words, and each output line carries only its own result pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame start marker, high during bit-clock 0 |
| ser_in | input | 2 | Serial data, bit 0 stream 0, bit 1 stream 1 |
| volume | input | 8 | Master volume, 0x00 mute, 0xFF unity |
| res_l0 | input | 16 | Result left word, stream 0 |
| res_r0 | input | 16 | Result right word, stream 0 |
| res_l1 | input | 16 | Result left word, stream 1 |
| res_r1 | input | 16 | Result right word, stream 1 |
| ser_out | output | 2 | Serial result data, bit 0 stream 0, bit 1 stream 1 |
| smp_valid | output | 1 | One-cycle strobe for a new input pair |
| in_l0 | output | 16 | Captured left word, stream 0 |
| in_r0 | output | 16 | Captured right word, stream 0 |
| in_l1 | output | 16 | Captured left word, stream 1 |
| in_r1 | output | 16 | Captured right word, stream 1 |

## Verification
If the bit counter is off by one, every captured word comes out shifted or rotated by one bit position. The strobe then lands a cycle early or late, and this is visible at the first frame boundary. If the output shift register is wrong, the error shows on the serial lines one frame after the result pair was loaded. A swapped or truncated gain product shows up as wrong serial words as soon as a nonzero, non-unity volume is applied. An early sync that fails to discard its partial input corrupts the words captured at the end of the next full frame.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int SMP_W = 16;
    localparam int VOL_W = 8;
    localparam int LANES = 2;
    localparam int FRAME_BITS = 2 * SMP_W;

    typedef struct packed {
        logic signed [SMP_W-1:0] left;
        logic signed [SMP_W-1:0] right;
    } stereo_t;

    // floor(s * (v + 1) / 2^VOL_W), zero when v is zero
    function automatic logic signed [SMP_W-1:0] apply_gain(
        input logic signed [SMP_W-1:0] s,
        input logic [VOL_W-1:0]        v
    );
        logic signed [VOL_W+1:0]       g;
        logic signed [SMP_W+VOL_W+1:0] prod;
        if (v == '0) return '0;
        g    = {2'b00, v} + 1'b1;
        prod = s * g;
        return prod[SMP_W+VOL_W-1:VOL_W];
    endfunction
endpackage

// File: rtl/sap_frame_timer.sv
module sap_frame_timer #(
    parameter int FRAME_BITS = sap_pkg::FRAME_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic sync,
    output logic last,
    output logic valid
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx;

    always_comb begin
        idx  = sync ? '0 : cnt;
        last = (idx == CW'(FRAME_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            cnt   <= last ? '0 : idx + 1'b1;
            valid <= last;
        end
    end
endmodule

// File: rtl/sap_deser_lane.sv
module sap_deser_lane
    import sap_pkg::*;
#(
    parameter int FRAME_BITS = sap_pkg::FRAME_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sync,
    input  logic    last,
    input  logic    bit_in,
    output stereo_t word
);
    logic [FRAME_BITS-1:0] sh;
    logic [FRAME_BITS-1:0] sh_n;

    always_comb begin
        if (sync) sh_n = {{(FRAME_BITS-1){1'b0}}, bit_in};
        else      sh_n = {sh[FRAME_BITS-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            word <= '0;
        end else begin
            sh <= sh_n;
            if (last) word <= stereo_t'(sh_n);
        end
    end
endmodule

// File: rtl/sap_ser_lane.sv
module sap_ser_lane
    import sap_pkg::*;
#(
    parameter int FRAME_BITS = sap_pkg::FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last,
    input  logic [VOL_W-1:0] vol,
    input  stereo_t          res,
    output logic             bit_out
);
    logic [FRAME_BITS-1:0] sh;
    stereo_t               scaled;

    always_comb begin
        scaled.left  = apply_gain(res.left, vol);
        scaled.right = apply_gain(res.right, vol);
    end

    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (last) sh <= scaled;
        else           sh <= {sh[FRAME_BITS-2:0], 1'b0};
    end

    assign bit_out = sh[FRAME_BITS-1];
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
    import sap_pkg::*;
#(
    parameter int LN = sap_pkg::LANES,
    parameter int FB = sap_pkg::FRAME_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync,
    input  logic [LN-1:0]           ser_in,
    input  logic [VOL_W-1:0]        volume,
    input  logic signed [SMP_W-1:0] res_l0,
    input  logic signed [SMP_W-1:0] res_r0,
    input  logic signed [SMP_W-1:0] res_l1,
    input  logic signed [SMP_W-1:0] res_r1,
    output logic [LN-1:0]           ser_out,
    output logic                    smp_valid,
    output logic signed [SMP_W-1:0] in_l0,
    output logic signed [SMP_W-1:0] in_r0,
    output logic signed [SMP_W-1:0] in_l1,
    output logic signed [SMP_W-1:0] in_r1
);
    logic             frame_last;
    logic [VOL_W-1:0] vol_q;
    stereo_t          cap   [LN];
    stereo_t          res_v [LN];

    always_comb begin
        res_v[0] = '{left: res_l0, right: res_r0};
        res_v[1] = '{left: res_l1, right: res_r1};
    end

    always_ff @(posedge clk) begin
        if (rst) vol_q <= '0;
        else     vol_q <= volume;
    end

    sap_frame_timer #(.FRAME_BITS(FB)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .sync  (sync),
        .last  (frame_last),
        .valid (smp_valid)
    );

    for (genvar k = 0; k < LN; k++) begin : g_lane
        sap_deser_lane #(.FRAME_BITS(FB)) i_rx (
            .clk    (clk),
            .rst    (rst),
            .sync   (sync),
            .last   (frame_last),
            .bit_in (ser_in[k]),
            .word   (cap[k])
        );
        sap_ser_lane #(.FRAME_BITS(FB)) i_tx (
            .clk     (clk),
            .rst     (rst),
            .last    (frame_last),
            .vol     (vol_q),
            .res     (res_v[k]),
            .bit_out (ser_out[k])
        );
    end

    assign in_l0 = cap[0].left;
    assign in_r0 = cap[0].right;
    assign in_l1 = cap[1].left;
    assign in_r1 = cap[1].right;
endmodule

// File: rtl/stereo_serial_port_chk.sv
module stereo_serial_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        sync,
    input logic        last,
    input logic [7:0]  volume,
    input logic        smp_valid,
    input logic [1:0]  ser_out,
    input logic [15:0] in_l0,
    input logic [15:0] in_r1
);
    // R3: strobe lasts a single cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R3: strobe only follows the last bit of a frame
    a_r3_valid_after_last: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(last));

    // R3: words hold between strobes
    a_r3_words_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(in_l0) && $stable(in_r1)));

    // R4: a sync never yields a strobe in the next cycle
    a_r4_sync_no_valid: assert property (@(posedge clk) disable iff (rst)
        sync |=> !smp_valid);

    // R7: mute volume loaded at the frame end gives silent outputs
    a_r7_mute_silent: assert property (@(posedge clk) disable iff (rst)
        (last && $past(volume) == 8'h00) |=> (ser_out == 2'b00));
endmodule

bind stereo_serial_port stereo_serial_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .sync      (sync),
    .last      (frame_last),
    .volume    (volume),
    .smp_valid (smp_valid),
    .ser_out   (ser_out),
    .in_l0     (in_l0),
    .in_r1     (in_r1)
);

// File: tb/test_stereo_serial_port.sv
module test_stereo_serial_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        sync;
    logic [1:0]  ser_in;
    logic [7:0]  volume;
    logic [15:0] res_l0, res_r0, res_l1, res_r1;
    logic [1:0]  ser_out;
    logic        smp_valid;
    logic [15:0] in_l0, in_r0, in_l1, in_r1;

    always #5 clk = ~clk;

    stereo_serial_port i_stereo_serial_port (
        .clk(clk), .rst(rst), .sync(sync), .ser_in(ser_in), .volume(volume),
        .res_l0(res_l0), .res_r0(res_r0), .res_l1(res_l1), .res_r1(res_r1),
        .ser_out(ser_out), .smp_valid(smp_valid),
        .in_l0(in_l0), .in_r0(in_r0), .in_l1(in_l1), .in_r1(in_r1)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // pending input-word expectation and output-word expectation
    bit          pend_in  = 0;
    logic [31:0] pend_d0, pend_d1;
    logic [31:0] held_d0 = '0, held_d1 = '0;
    bit          exp_ok   = 0;
    logic [31:0] exp_o0, exp_o1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_gain(input logic [15:0] s, input logic [7:0] v);
        int p;
        if (v == 8'h00) return 16'h0000;
        p = $signed(s) * (int'(v) + 1);
        return 16'(p >>> 8);
    endfunction

    // checks done on the first bit-clock of every frame or partial frame
    task automatic frame_start_checks();
        if (pend_in) begin
            chk("R3 strobe at frame end", 32'(smp_valid), 32'd1);
            chk("R2/R9 stream0 words", {in_l0, in_r0}, pend_d0);
            chk("R2/R9 stream1 words", {in_l1, in_r1}, pend_d1);
            held_d0 = pend_d0;
            held_d1 = pend_d1;
            pend_in = 0;
        end
    endtask

    task automatic frame(input logic [31:0] d0, input logic [31:0] d1,
                         input logic [15:0] pl0, input logic [15:0] pr0,
                         input logic [15:0] pl1, input logic [15:0] pr1,
                         input logic [7:0] v, input logic [7:0] v_last,
                         input string greq);
        logic [31:0] cap0, cap1;
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            cap0[31-b] = ser_out[0];
            cap1[31-b] = ser_out[1];
            if (b == 0) frame_start_checks();
            else if (b == 16) begin
                chk("R3 no strobe mid frame", 32'(smp_valid), 32'd0);
                chk("R3 words held", {in_l0, in_r0}, held_d0);
            end
            sync   = (b == 0);
            ser_in = {d1[31-b], d0[31-b]};
            volume = (b == 31) ? v_last : v;
            if (b == 0) begin
                res_l0 = pl0; res_r0 = pr0; res_l1 = pl1; res_r1 = pr1;
            end
            @(posedge clk);
        end
        if (exp_ok) begin
            chk({greq, " R5/R9 stream0 serial out"}, cap0, exp_o0);
            chk({greq, " R5/R9 stream1 serial out"}, cap1, exp_o1);
        end
        exp_o0  = {ref_gain(pl0, v), ref_gain(pr0, v)};
        exp_o1  = {ref_gain(pl1, v), ref_gain(pr1, v)};
        exp_ok  = 1;
        pend_in = 1;
        pend_d0 = d0;
        pend_d1 = d1;
    endtask

    // R4: a frame cut short by the next sync
    task automatic partial(input int n);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            if (b == 0) frame_start_checks();
            else begin
                chk("R4 no strobe in partial frame", 32'(smp_valid), 32'd0);
                chk("R4 words unchanged by partial", {in_l1, in_r1}, held_d1);
            end
            sync   = (b == 0);
            ser_in = 2'($urandom);
            @(posedge clk);
        end
        exp_ok = 0;
    endtask

    function automatic logic [15:0] rnd16();
        return 16'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        rst = 1; sync = 0; ser_in = 0; volume = 8'hFF;
        res_l0 = 0; res_r0 = 0; res_l1 = 0; res_r1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", 32'(smp_valid), 32'd0);
        chk("R1 reset words", {in_l0, in_r1}, 32'd0);
        chk("R1 reset serial", 32'(ser_out), 32'd0);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 after reset words", {in_r0, in_l1}, 32'd0);
        chk("R1 after reset serial", 32'(ser_out), 32'd0);
        exp_o0 = '0; exp_o1 = '0; exp_ok = 1;

        // R6 unity gain with extreme values
        frame(32'h8000_7FFF, 32'h0001_FFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF,
              8'hFF, 8'hFF, "R6");
        // R7 mute
        frame(32'hA5A5_5A5A, 32'h1234_FEDC, 16'h7FFF, 16'h8000, 16'h4000, 16'hC000,
              8'h00, 8'h00, "R7");
        // R6 half-ish gain, negative flooring
        frame(32'hFFFF_0000, 32'h0000_FFFF, 16'hFFFF, 16'h8001, 16'h0101, 16'h7FFF,
              8'h7F, 8'h7F, "R6");
        // R8 late volume change ignored for this frame
        frame(32'h0F0F_F0F0, 32'h3333_CCCC, 16'h1234, 16'hEDCB, 16'h7000, 16'h9000,
              8'h40, 8'h00, "R8");
        frame(32'h1111_2222, 32'h4444_8888, 16'h2000, 16'hE000, 16'h0800, 16'hF800,
              8'h01, 8'h01, "R6");
        // R4 early sync after 10 bits, then after 31 bits
        partial(10);
        frame(32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h0100, 16'hFF00, 16'h0010, 16'hFFF0,
              8'hFF, 8'hFF, "R4");
        partial(31);
        frame(32'h0123_4567, 32'h89AB_CDEF, 16'h3FFF, 16'hC001, 16'h0003, 16'hFFFD,
              8'hC0, 8'hC0, "R6");

        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (i % 9 == 0) v = 8'h00;
            frame({rnd16(), rnd16()}, {rnd16(), rnd16()},
                  rnd16(), rnd16(), rnd16(), rnd16(), v, v, "R6 random");
        end
        // flush the last result
        frame(32'h0, 32'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFF, 8'hFF, "R5 flush");
        @(negedge clk);
        frame_start_checks();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule